// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block turns a configuration request (bus number, device slot, function number and register offset) into two values that a host bridge needs for one PCI configuration access: a 24-bit offset into a fixed 16 MB configuration aperture, and a 16-bit window-map value. The map value supplies the cycle type and the uppermost address byte of the PCI access.

Bus 0 is the local segment. Requests for it become type-0 cycles, in which the device is chosen by a single set address line. Requests for every other bus become type-1 cycles, which carry bus, slot and function as encoded fields.

On the type-0 path the select line for a slot lands in one of two places. For slots 0 to 12 it is an offset bit. For slots 13 to 20 it is a bit of the map value's upper byte. A later stage writes that byte into the aperture's map register, so its bits become PCI address bits 31:24. Slots 21 to 31 have no line left and are refused.

The generator accepts a request on any cycle it is presented. It answers through a single registered stage: one clock later it raises either a valid pulse with the result or an error pulse.

Top module: `cfg_addr_gen`

## Requirements
- R1: After reset, `out_valid`, `err_range` and `err_align` are all low, and they stay low while no request is presented.
- R2: A request sampled with `req_valid` high at a rising edge yields its result on the outputs right after the next rising edge. Each of `out_valid`, `err_range` and `err_align` is a one-cycle pulse for each request, and `out_valid` is never high together with an error flag.
- R3: The map value's bits 3:1 always hold the configuration type code 3'b101. Bit 0 is 0 for bus 0 (low address bits forced to zero) and 1 for any other bus (low address bits passed from the local address). On an accepted bus-0 request the map value is therefore 16'h000A plus any select bit from R5. On any other bus it is exactly 16'h000B.
- R4: For bus 0 with slot 0 to 12, the offset has the function in bits 10:8, the register offset in bits 7:0, and exactly one further bit set, at position slot + 11. Its bits 15:4 of the map value are zero.
- R5: For bus 0 with slot 13 to 20, the map value has one bit set at position slot − 5 (bits 8 to 15), in addition to 4'hA. The offset holds only the function (bits 10:8) and the register offset (bits 7:0), with bits 23:11 zero.
- R6: For any bus other than 0, the offset is bus[7:0] in bits 23:16, slot[4:0] in bits 15:11, function[2:0] in bits 10:8 and the register offset in bits 7:0.
- R7: A slot above 31, a function above 7, or a bus-0 request with slot 21 to 31 raises `err_range` and produces no `out_valid`.
- R8: A bus-0 request whose register offset has a nonzero bits 1:0 raises `err_align` and produces no `out_valid`. Requests to other buses accept any byte offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_bus | input | 8 | Target bus number |
| req_slot | input | 6 | Device slot; values above 31 are out of range |
| req_func | input | 4 | Function number; values above 7 are out of range |
| req_reg | input | 8 | Byte offset of the configuration register |
| out_valid | output | 1 | Result pulse, one cycle per good request |
| cfg_offset | output | 24 | Offset into the 16 MB configuration aperture |
| map_value | output | 16 | Window-map value: type code, low-address mode, upper address byte |
| err_range | output | 1 | Request refused: slot or function out of range |
| err_align | output | 1 | Request refused: misaligned type-0 register offset |

## Verification
The embedded properties check the following on every cycle:
- the single-cycle answer timing and the exclusivity of result and error;
- the fixed type code and the low-address bit that matches the decoded cycle type;
- that an accepted type-0 result carries exactly one select line across offset bits 23:11 and map bits 15:8;
- that a type-1 result leaves the map's upper bits clear.

Only the bench's sweep shows the rest. That covers where the select line lands for each slot, the exact placement of bus, slot and function fields, and the edges at slots 12/13, 20/21 and 31/32 and at function 7/8. The sweep runs every slot and several functions, buses and offsets, both one-per-cycle and with idle gaps.

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen #(
  parameter int BUS_W  = 8,
  parameter int SLOT_W = 6,
  parameter int FUNC_W = 4,
  parameter int LOW_MAX_SLOT  = 12,
  parameter int HIGH_MAX_SLOT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [7:0]        req_reg,
  output logic              out_valid,
  output logic [23:0]       cfg_offset,
  output logic [15:0]       map_value,
  output logic              err_range,
  output logic              err_align
);
  localparam logic [3:0] MAP_T0 = 4'b1010;
  localparam logic [3:0] MAP_T1 = 4'b1011;

  logic        local_seg, bad_range, bad_align;
  logic [23:0] off_nx;
  logic [15:0] map_nx;

  assign local_seg = (req_bus == '0);
  assign bad_range = (int'(req_slot) > 31) || (int'(req_func) > 7) ||
                     (local_seg && int'(req_slot) > HIGH_MAX_SLOT);
  assign bad_align = local_seg && (req_reg[1:0] != 2'b00);

  always_comb begin
    off_nx = {13'd0, req_func[2:0], req_reg};
    map_nx = {12'd0, MAP_T0};
    if (local_seg) begin
      if (int'(req_slot) <= LOW_MAX_SLOT)
        off_nx[int'(req_slot[4:0]) + 11] = 1'b1;
      else if (int'(req_slot) <= HIGH_MAX_SLOT)
        map_nx[int'(req_slot[4:0]) - 5] = 1'b1;
    end else begin
      off_nx = {req_bus[7:0], req_slot[4:0], req_func[2:0], req_reg};
      map_nx = {12'd0, MAP_T1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      err_range  <= 1'b0;
      err_align  <= 1'b0;
      cfg_offset <= '0;
      map_value  <= '0;
    end else begin
      out_valid <= req_valid && !bad_range && !bad_align;
      err_range <= req_valid && bad_range;
      err_align <= req_valid && bad_align;
      if (req_valid) begin
        cfg_offset <= off_nx;
        map_value  <= map_nx;
      end
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || err_range || err_align) |-> $past(req_valid));
  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(err_range || err_align));
  assert_type_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (map_value[3:1] == 3'b101 &&
                   map_value[0] == ($past(req_bus) != '0)));
  assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !map_value[0]) |->
      $countones({cfg_offset[23:11], map_value[15:8]}) == 1);
  assert_t1_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && map_value[0]) |-> map_value[15:4] == 12'd0);
  assert_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !map_value[0]) |-> cfg_offset[1:0] == 2'b00);
endmodule

// File: tb/cfg_addr_gen_test.sv
module cfg_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [5:0]  req_slot = '0;
  logic [3:0]  req_func = '0;
  logic [7:0]  req_reg = '0;
  logic        out_valid, err_range, err_align;
  logic [23:0] cfg_offset;
  logic [15:0] map_value;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
    .req_slot(req_slot), .req_func(req_func), .req_reg(req_reg),
    .out_valid(out_valid), .cfg_offset(cfg_offset), .map_value(map_value),
    .err_range(err_range), .err_align(err_align));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic quiet(input string req);
    check({out_valid, err_range, err_align} == 3'b000, req, "idle flags",
          {out_valid, err_range, err_align}, 0);
  endtask

  task automatic expect_result(input int b, input int s, input int f, input int r);
    bit t0, rng, aln, ok;
    logic [23:0] eoff;
    logic [15:0] emap;
    string tag;
    t0  = (b == 0);
    rng = (s > 31) || (f > 7) || (t0 && s > 20);
    aln = t0 && (r % 4 != 0);
    eoff = 24'(f % 8) * 256 + 24'(r);
    emap = t0 ? 16'hA : 16'hB;
    if (rng) tag = "R7";
    else if (aln) tag = "R8";
    else if (!t0) tag = "R6";
    else if (s <= 12) tag = "R4";
    else tag = "R5";
    if (!rng && !aln) begin
      if (!t0) eoff = eoff + 24'(b) * 65536 + 24'(s) * 2048;
      else if (s <= 12) eoff = eoff + (24'd1 << s) * 2048;
      else emap = emap + (16'd1 << (s - 5));
    end
    ok = (out_valid == !(rng || aln)) && (err_range == rng) && (err_align == aln);
    if (ok && out_valid) ok = (cfg_offset == eoff) && (map_value == emap);
    check(ok, tag, $sformatf("bus=%0d slot=%0d func=%0d reg=%0h {v,er,ea,off,map}", b, s, f, r),
          {29'd0, out_valid, err_range, err_align, cfg_offset, map_value},
          {29'd0, !(rng || aln), rng, aln, (rng || aln) ? cfg_offset : eoff,
           (rng || aln) ? map_value : emap});
  endtask

  initial begin
    int buses[3] = '{0, 1, 255};
    int funcs[5] = '{0, 3, 7, 8, 15};
    int regs[4]  = '{8'h00, 8'h04, 8'h3C, 8'hFD};
    repeat (3) @(negedge clk);
    quiet("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    quiet("R1");
    for (int bi = 0; bi < 3; bi++)
      for (int s = 0; s < 64; s++)
        for (int fi = 0; fi < 5; fi++)
          for (int ri = 0; ri < 4; ri++) begin
            req_bus = 8'(buses[bi]); req_slot = 6'(s);
            req_func = 4'(funcs[fi]); req_reg = 8'(regs[ri]);
            req_valid = 1'b1;
            @(negedge clk);
            expect_result(buses[bi], s, funcs[fi], regs[ri]);
            if (ri == 3) begin
              req_valid = 1'b0;
              @(negedge clk);
              quiet("R2");
            end
          end
    req_valid = 1'b0;
    @(negedge clk);
    quiet("R2");
    for (int b = 2; b < 256; b += 37) begin
      req_bus = 8'(b); req_slot = 6'(31 - b % 32); req_func = 4'(b % 8);
      req_reg = 8'(b); req_valid = 1'b1;
      @(negedge clk);
      expect_result(b, 31 - b % 32, b % 8, b % 256);
    end
    req_valid = 1'b0;
    @(negedge clk);
    quiet("R2");
    done = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end
endmodule